// File: doc/BRIEF.md
# Dual Reference Clock Selector

This block picks one of two reference clocks, a primary and a secondary, and passes it on to a PLL phase detector. A free-running system clock watches both references: each reference is brought into the system domain through a synchronizer, and its rising edges are counted over fixed windows. A reference with too few edges in a window is flagged as absent. Frequencies below the detection limit therefore count as absent, and a detection-disable input can mask this for slow references.

In manual mode an external select pin chooses the reference. In automatic mode the primary is always preferred. The selector falls back to the secondary only while the primary is absent, and it goes back to the primary once the primary is valid again. The selected clock passes through a break-before-make mux, so no clock pulse is shortened at a switchover. The output stays low after reset until a selection whose reference is valid has been made. One status output reports either the validity of the selected reference or which reference is selected.

Top module: `refsel_top`

## Requirements
- R1: With `auto_mode_i` = 0, `sel_pri_i` = 1 selects the primary and 0 selects the secondary. The pin passes through two synchronizer stages.
- R2: With `auto_mode_i` = 1, the primary is selected whenever it is valid, even when the secondary is valid too.
- R3: With `auto_mode_i` = 1, the secondary is selected while the primary is invalid and the secondary is valid. The primary is selected again once it is valid.
- R4: A reference is valid when at least THRESH synchronized rising edges fell in the last completed window of WINDOW system cycles. Validity changes only at a window end, and both references are invalid after reset.
- R5: With `stat_sel_i` = 0, `status_o` is 1 when the selected reference is valid and 0 otherwise.
- R6: With `stat_sel_i` = 1, `status_o` is 1 while the primary is selected and 0 while the secondary is selected.
- R7: `det_off_i` = 1 makes both references count as valid, both for the status output and for the automatic choice.
- R8: After reset, `clk_o` stays low until the first selection whose reference is valid.
- R9: Every high and low phase of `clk_o` lasts at least the shorter half period of the running references. The two enables are never high together.
- R10: Once a selection has been stable long enough for the handover to finish, `clk_o` follows the selected reference exactly. A reference that is no longer requested is released after KILL_CYCLES system cycles, even if its clock has stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys_i | input | 1 | Free-running system clock for monitoring and selection |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_pri_i | input | 1 | Primary reference clock |
| ref_sec_i | input | 1 | Secondary reference clock |
| auto_mode_i | input | 1 | 0 manual selection, 1 automatic primary-preferred selection |
| sel_pri_i | input | 1 | Manual select pin: 1 primary, 0 secondary |
| stat_sel_i | input | 1 | Status meaning: 0 validity, 1 selected reference |
| det_off_i | input | 1 | 1 forces both references to count as valid |
| clk_o | output | 1 | Selected reference clock |
| status_o | output | 1 | Status as chosen by `stat_sel_i` |

## Verification
The assertions assume that the mode, status-select and detection-disable inputs change rarely and stay steady across a system clock edge. They also assume that each reference holds every level for at least two system cycles, so the synchronizer sees every edge. The bench generates both references from the system clock, with half periods of several cycles, and changes them and every configuration input only at the falling system edge. A reference is stopped only after it has finished its high phase, so the bench never creates a shortened pulse that the block would then be blamed for.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int unsigned IDX_PRI = 0;
  localparam int unsigned IDX_SEC = 1;
  localparam int unsigned N_REF   = 2;
endpackage

// File: rtl/refsel_activity_mon.sv
module refsel_activity_mon #(
  parameter int unsigned WINDOW = 64,
  parameter int unsigned THRESH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic valid_o
);
  localparam int unsigned WW = $clog2(WINDOW);
  localparam int unsigned CW = $clog2(THRESH + 1);

  logic [2:0]    sync_q;
  logic          edge_w;
  logic          win_end;
  logic [WW-1:0] win_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], ref_i};

  assign edge_w  = sync_q[1] & ~sync_q[2];
  assign win_end = (win_q == WW'(WINDOW - 1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      win_q   <= '0;
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else if (win_end) begin
      win_q   <= '0;
      cnt_q   <= '0;
      valid_o <= (32'(cnt_q) + 32'(edge_w)) >= THRESH;
    end else begin
      win_q <= win_q + 1'b1;
      if (edge_w && (32'(cnt_q) < THRESH)) cnt_q <= cnt_q + 1'b1;
    end

  // validity only moves at a window boundary
  p_hold_mid_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> $stable(valid_o));
endmodule

// File: rtl/refsel_decide.sv
module refsel_decide
  import refsel_pkg::*;
#(
  parameter int unsigned KILL_CYCLES = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_i,
  input  logic             sel_i,
  input  logic             det_off_i,
  input  logic [N_REF-1:0] valid_i,
  output logic [N_REF-1:0] ok_o,
  output logic             use_pri_o,
  output logic             armed_o,
  output logic [N_REF-1:0] req_o,
  output logic [N_REF-1:0] kill_o
);
  localparam int unsigned KW = $clog2(KILL_CYCLES);

  logic [1:0] sel_sync_q;
  logic       want_pri;
  logic       armed_d;

  assign ok_o = valid_i | {N_REF{det_off_i}};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sel_sync_q <= '0;
    else         sel_sync_q <= {sel_sync_q[0], sel_i};

  // automatic: primary unless it is gone and the secondary is alive
  assign want_pri = auto_i ? (ok_o[IDX_PRI] | ~ok_o[IDX_SEC]) : sel_sync_q[1];
  assign armed_d  = armed_o | (want_pri ? ok_o[IDX_PRI] : ok_o[IDX_SEC]);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      use_pri_o <= 1'b1;
      armed_o   <= 1'b0;
      req_o     <= '0;
    end else begin
      use_pri_o      <= want_pri;
      armed_o        <= armed_d;
      req_o[IDX_PRI] <= armed_d & want_pri;
      req_o[IDX_SEC] <= armed_d & ~want_pri;
    end

  // a leg idle for KILL_CYCLES is forced off: its clock may have stopped
  for (genvar g = 0; g < N_REF; g++) begin : g_idle
    logic [KW-1:0] idle_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        idle_q    <= '0;
        kill_o[g] <= 1'b0;
      end else if (req_o[g]) begin
        idle_q    <= '0;
        kill_o[g] <= 1'b0;
      end else if (idle_q == KW'(KILL_CYCLES - 1)) begin
        kill_o[g] <= 1'b1;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
  end

  p_prefer_pri_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(auto_i) && $past(ok_o[IDX_PRI])) |-> use_pri_o);

  p_fallback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(auto_i) && !$past(ok_o[IDX_PRI]) && $past(ok_o[IDX_SEC])) |-> !use_pri_o);

  p_armed_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |=> armed_o);

  p_req_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(req_o) <= 1);
endmodule

// File: rtl/refsel_gf_mux.sv
module refsel_gf_mux
  import refsel_pkg::*;
(
  input  logic             clk_sys_i,
  input  logic             rst_ni,
  input  logic [N_REF-1:0] clk_i,
  input  logic [N_REF-1:0] req_i,
  input  logic [N_REF-1:0] kill_i,
  output logic             clk_o
);
  logic [N_REF-1:0] en_w;

  for (genvar g = 0; g < N_REF; g++) begin : g_leg
    logic       clr_n;
    logic       want;
    logic [1:0] sync_q;
    logic       en_q;

    assign clr_n = rst_ni & ~kill_i[g];
    // break before make: wait until the other leg has dropped
    assign want  = req_i[g] & ~en_w[N_REF-1-g];

    always_ff @(posedge clk_i[g] or negedge clr_n)
      if (!clr_n) sync_q <= '0;
      else        sync_q <= {sync_q[0], want};

    // enable moves only while this clock is low
    always_ff @(negedge clk_i[g] or negedge clr_n)
      if (!clr_n) en_q <= 1'b0;
      else        en_q <= sync_q[1];

    assign en_w[g] = en_q;
  end

  assign clk_o = |(clk_i & en_w);

  p_bbm_r9: assert property (@(posedge clk_sys_i) disable iff (!rst_ni)
    $onehot0(en_w));
endmodule

// File: rtl/refsel_top.sv
module refsel_top
  import refsel_pkg::*;
#(
  parameter int unsigned WINDOW      = 64,
  parameter int unsigned THRESH      = 4,
  parameter int unsigned KILL_CYCLES = 256
) (
  input  logic clk_sys_i,
  input  logic rst_ni,
  input  logic ref_pri_i,
  input  logic ref_sec_i,
  input  logic auto_mode_i,
  input  logic sel_pri_i,
  input  logic stat_sel_i,
  input  logic det_off_i,
  output logic clk_o,
  output logic status_o
);
  logic [N_REF-1:0] refs_w;
  logic [N_REF-1:0] valid_w;
  logic [N_REF-1:0] ok_w;
  logic [N_REF-1:0] req_w;
  logic [N_REF-1:0] kill_w;
  logic             use_pri_w;
  logic             armed_w;

  assign refs_w[IDX_PRI] = ref_pri_i;
  assign refs_w[IDX_SEC] = ref_sec_i;

  for (genvar g = 0; g < N_REF; g++) begin : g_mon
    refsel_activity_mon #(
      .WINDOW (WINDOW),
      .THRESH (THRESH)
    ) u_mon (
      .clk_i   (clk_sys_i),
      .rst_ni  (rst_ni),
      .ref_i   (refs_w[g]),
      .valid_o (valid_w[g])
    );
  end

  refsel_decide #(
    .KILL_CYCLES (KILL_CYCLES)
  ) u_dec (
    .clk_i     (clk_sys_i),
    .rst_ni    (rst_ni),
    .auto_i    (auto_mode_i),
    .sel_i     (sel_pri_i),
    .det_off_i (det_off_i),
    .valid_i   (valid_w),
    .ok_o      (ok_w),
    .use_pri_o (use_pri_w),
    .armed_o   (armed_w),
    .req_o     (req_w),
    .kill_o    (kill_w)
  );

  refsel_gf_mux u_mux (
    .clk_sys_i (clk_sys_i),
    .rst_ni    (rst_ni),
    .clk_i     (refs_w),
    .req_i     (req_w),
    .kill_i    (kill_w),
    .clk_o     (clk_o)
  );

  assign status_o = stat_sel_i ? use_pri_w
                               : (use_pri_w ? ok_w[IDX_PRI] : ok_w[IDX_SEC]);

  p_quiet_until_armed_r8: assert property (@(posedge clk_sys_i) disable iff (!rst_ni)
    !armed_w |-> !clk_o);
endmodule

// File: tb/refsel_top_test.sv
`timescale 1ns/1ps
module refsel_top_test;
  localparam int WIN  = 64;
  localparam int TH   = 4;
  localparam int KILL = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_pri = 1'b0, ref_sec = 1'b0;
  logic auto_m = 1'b0, sel_p = 1'b1, stat_s = 1'b0, det_off = 1'b0;
  logic clk_o, status_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  refsel_top #(.WINDOW(WIN), .THRESH(TH), .KILL_CYCLES(KILL)) uut (
    .clk_sys_i(clk), .rst_ni(rst_ni), .ref_pri_i(ref_pri), .ref_sec_i(ref_sec),
    .auto_mode_i(auto_m), .sel_pri_i(sel_p), .stat_sel_i(stat_s), .det_off_i(det_off),
    .clk_o(clk_o), .status_o(status_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference generators, moved only on falling system edges
  int  half[2] = '{2, 3};
  bit  run[2]  = '{1, 1};
  int  pcnt[2] = '{0, 0};
  bit  lvl[2]  = '{0, 0};
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (run[i] || lvl[i]) begin
        pcnt[i]++;
        if (pcnt[i] >= half[i]) begin lvl[i] = ~lvl[i]; pcnt[i] = 0; end
      end
    end
    ref_pri = lvl[0];
    ref_sec = lvl[1];
  end

  // behavioural model, advanced once per system clock
  int h1[2], h2[2], h3[2], wc[2], ec[2];
  bit mv[2];
  bit s1, s2, m_pri, m_arm;
  int since;
  always @(posedge clk) begin
    #2;
    if (!rst_ni) begin
      for (int i = 0; i < 2; i++) begin h1[i]=0; h2[i]=0; h3[i]=0; wc[i]=0; ec[i]=0; mv[i]=0; end
      s1 = 0; s2 = 0; m_pri = 1; m_arm = 0; since = 0;
    end else if (!done) begin
      bit okp, oks, want, arm_n, exp_st;
      int settle;
      okp   = det_off || mv[0];
      oks   = det_off || mv[1];
      want  = auto_m ? (okp || !oks) : s2;
      arm_n = m_arm || (want ? okp : oks);
      if (want != m_pri || arm_n != m_arm) since = 0; else since++;
      m_pri = want;
      m_arm = arm_n;
      for (int i = 0; i < 2; i++) begin
        int e;
        e = (h2[i] == 1 && h3[i] == 0) ? 1 : 0;
        if (wc[i] == WIN - 1) begin mv[i] = (ec[i] + e) >= TH; ec[i] = 0; wc[i] = 0; end
        else begin wc[i]++; ec[i] += e; end
        h3[i] = h2[i]; h2[i] = h1[i]; h1[i] = lvl[i];
      end
      s2 = s1; s1 = sel_p;
      exp_st = stat_s ? m_pri : (m_pri ? (det_off || mv[0]) : (det_off || mv[1]));
      check(stat_s ? "R6 status" : "R5 status", status_o, exp_st);
      settle = KILL + 20 + 6 * (half[0] + half[1]);
      if (!m_arm) check("R8 quiet", clk_o, 0);
      else if (since >= settle) check("R10 follow", clk_o, m_pri ? lvl[0] : lvl[1]);
    end
  end

  // pulse width watch
  realtime last_t = 0.0;
  always @(clk_o) begin
    if (rst_ni && !done && last_t > 0.0) begin
      checks++;
      if ($realtime - last_t < 15.0) begin
        errors++;
        $display("FAIL R9: actual width=%0t expected>=15ns at %0t", $realtime - last_t, $time);
      end
    end
    last_t = $realtime;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    cyc(5);
    check("R4 reset status", status_o, 0);
    check("R8 reset clock", clk_o, 0);
    rst_ni = 1'b1;
    cyc(30);
    check("R4 no verdict before window end", status_o, 0);
    check("R8 no clock before valid", clk_o, 0);
    cyc(570);
    check("R5 manual primary valid", status_o, 1);
    stat_s = 1'b1;
    cyc(1);
    check("R1 manual primary", status_o, 1);
    sel_p = 1'b0;
    cyc(600);
    check("R1 manual secondary", status_o, 0);
    check("R6 shows secondary", status_o, 0);
    auto_m = 1'b1;
    cyc(600);
    check("R2 auto prefers primary", status_o, 1);
    run[0] = 0;
    cyc(800);
    check("R3 fallback to secondary", status_o, 0);
    stat_s = 1'b0;
    cyc(1);
    check("R5 secondary valid", status_o, 1);
    stat_s = 1'b1;
    run[0] = 1; pcnt[0] = 0;
    cyc(800);
    check("R3 revert to primary", status_o, 1);
    half[0] = 40;
    cyc(900);
    check("R4 slow primary flagged", status_o, 0);
    det_off = 1'b1;
    cyc(900);
    check("R7 auto takes slow primary", status_o, 1);
    stat_s = 1'b0;
    cyc(1);
    check("R7 validity forced", status_o, 1);
    det_off = 1'b0; auto_m = 1'b0; sel_p = 1'b1;
    cyc(300);
    check("R5 slow primary invalid", status_o, 0);
    finish_run();
  end
endmodule